// File: doc/BRIEF.md
# Alert interrupt controller

This block turns a set of event flags into one open-drain interrupt line and takes part in the SMBus alert-response read. Each event source pulses a set input, and the flag stays up until software reads and clears it (a per-bit clear pulse) or writes the clear-all bit. An 8-bit mask chooses which flags may raise the interrupt. The line is pulled low while any unmasked flag is up, but its state only changes while no bus transaction is in progress.

When the host reads the alert response address and the interrupt is pending, the block acknowledges. It then sends its own 7-bit address MSB first with a 0 in the last bit, sampling SDA on every rising SCL edge. If it drives a 1 but reads a 0, a device with a lower address is also answering. The block then lets go of SDA for the rest of that transaction and keeps its interrupt for a later attempt. A completed send, or a write of the release bit, lets the line go. The line can only pull low again once the masked condition has fully cleared.

The register write path, the start detector and the transaction-active flag come from the surrounding bus slave. All pins are plain control and status signals with no flow control.

Top module: `alert_irq_ctrl`

## Requirements
- R1: A pulse on `evt_set[i]` sets flag i, which holds until a pulse on `evt_rdclr[i]`. A set and a clear of the same bit in the same cycle leave the bit set. The flags are visible on `evt_flags`.
- R2: A write to the control register (`ctl_wr`) with `reg_wdata[7]`=1 clears every flag.
- R3: The interrupt condition is any bit of `evt_flags & mask`. The mask is loaded by `mask_wr` from `reg_wdata` and resets to 00h. While armed and outside a transaction, `int_pull_low` follows the condition. `int_pending` always equals `int_pull_low`.
- R4: `int_pull_low` does not change while `txn_active` is 1, whether it would assert, clear or release. Pending changes take effect after `txn_active` falls.
- R5: A control write with `reg_wdata[6]`=1 releases the interrupt. If it arrives during a transaction, the release is held and applied when the transaction ends.
- R6: After a release, the interrupt stays off even if new unmasked flags arrive. It re-arms only after the masked condition has been zero outside a transaction.
- R7: After a start, the block acknowledges the address byte 19h (alert address 0001100, read bit 1) by pulling SDA low during the ninth SCL clock, but only while `int_pull_low` is 1. For other bytes, or with no interrupt pending, it never drives SDA.
- R8: After the acknowledge, the block sends `{DEV_ADDR,1'b0}` MSB first. It changes its SDA drive only on falling SCL edges.
- R9: If the block sends a 1 and samples 0 on a rising SCL edge, it stops driving SDA for the rest of the transaction. The interrupt stays asserted.
- R10: When all 8 address bits are sent without a loss, the interrupt is released once the transaction ends. R6 then governs re-arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | EVT_W | One-cycle pulses that set event flags |
| evt_rdclr | input | EVT_W | One-cycle read-and-clear pulses per flag |
| reg_wdata | input | 8 | Register write data |
| mask_wr | input | 1 | Write strobe for the interrupt mask |
| ctl_wr | input | 1 | Write strobe for the clear-control register (bit 7 clear all, bit 6 release) |
| txn_active | input | 1 | High while a bus transaction is in progress |
| bus_start | input | 1 | Pulse from the start detector |
| scl_in | input | 1 | Sampled SCL |
| sda_in | input | 1 | Sampled SDA line |
| sda_pull_low | output | 1 | Open-drain SDA drive (1 = pull low) |
| int_pull_low | output | 1 | Open-drain interrupt drive (1 = pull low) |
| int_pending | output | 1 | Readable pending status |
| evt_flags | output | EVT_W | Current event flags |

## Verification
The bench builds the block with eight event bits and device address 2Ah, so the sent byte 54h alternates 0 and 1. This lets it check each bit of the send sequence, and lets a competing device win on the first 1 bit, after which every later bit must be released. Having the full eight-bit mask lets one vector table cover the masked, unmasked and fault bits together. Directed cases then cover deferral during transactions, release without re-arm, and alert reads that must not be answered.

// File: rtl/alert_irq_pkg.sv
package alert_irq_pkg;
  // Alert response address 0001100 followed by the read bit
  localparam logic [7:0] ARA_BYTE = 8'h19;
  localparam int CTL_REL_BIT  = 6;
  localparam int CTL_CLRA_BIT = 7;

  typedef enum logic [2:0] {
    ARB_IDLE,
    ARB_ADDR,
    ARB_ACK,
    ARB_TX,
    ARB_REL
  } arb_state_e;
endpackage

// File: rtl/alert_evt_flags.sv
module alert_evt_flags #(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_set,
  input  logic [EVT_W-1:0] evt_rdclr,
  input  logic             clr_all,
  output logic [EVT_W-1:0] flags
);
  logic [EVT_W-1:0] drop;
  assign drop = evt_rdclr | {EVT_W{clr_all}};

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~drop) | evt_set;
  end

  assert_set_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((flags & $past(evt_set)) == $past(evt_set)));
  assert_clear_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && evt_set == '0) |=> (flags == '0));
endmodule

// File: rtl/alert_int_gate.sv
module alert_int_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic txn_active,
  input  logic release_in,
  output logic int_pend
);
  logic release_pend;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_pend     <= 1'b0;
      release_pend <= 1'b0;
      armed        <= 1'b1;
    end else if (!txn_active) begin
      if (release_pend || release_in) begin
        int_pend     <= 1'b0;
        armed        <= 1'b0;
        release_pend <= 1'b0;
      end else if (!armed) begin
        int_pend <= 1'b0;
        if (!cond) armed <= 1'b1;
      end else begin
        int_pend <= cond;
      end
    end else if (release_in) begin
      release_pend <= 1'b1;
    end
  end

  assert_int_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_active |=> $stable(int_pend));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_active && (release_pend || release_in)) |=> !int_pend);
  assert_follow_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_active && !cond) |=> !int_pend);
  assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_pend) |-> $past(armed));
endmodule

// File: rtl/alert_ara_arb.sv
module alert_ara_arb
  import alert_irq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_start,
  input  logic scl_in,
  input  logic sda_in,
  input  logic int_pend,
  output logic sda_pull_low,
  output logic ara_won
);
  localparam logic [7:0] TX_BYTE = {DEV_ADDR, 1'b0};

  arb_state_e state;
  logic       scl_q;
  logic [3:0] cnt;
  logic [6:0] shreg;
  logic       hit;
  logic [2:0] bit_idx;
  logic [2:0] nxt_idx;
  logic       sda_low;
  logic       won;
  logic       scl_rise, scl_fall;

  assign scl_rise = scl_in & ~scl_q;
  assign scl_fall = ~scl_in & scl_q;
  assign nxt_idx  = bit_idx - 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ARB_IDLE;
      scl_q   <= 1'b1;
      cnt     <= '0;
      shreg   <= '0;
      hit     <= 1'b0;
      bit_idx <= '0;
      sda_low <= 1'b0;
      won     <= 1'b0;
    end else begin
      scl_q <= scl_in;
      won   <= 1'b0;
      if (bus_start) begin
        state   <= ARB_ADDR;
        cnt     <= '0;
        hit     <= 1'b0;
        sda_low <= 1'b0;
      end else begin
        case (state)
          ARB_ADDR: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[5:0], sda_in};
              cnt   <= cnt + 4'd1;
              if (cnt == 4'd7) hit <= ({shreg, sda_in} == ARA_BYTE) && int_pend;
            end else if (scl_fall && cnt == 4'd8) begin
              if (hit) begin
                sda_low <= 1'b1;
                state   <= ARB_ACK;
              end else begin
                state <= ARB_IDLE;
              end
            end
          end
          ARB_ACK: begin
            if (scl_fall) begin
              state   <= ARB_TX;
              bit_idx <= 3'd7;
              sda_low <= ~TX_BYTE[7];
            end
          end
          ARB_TX: begin
            if (scl_rise) begin
              if (TX_BYTE[bit_idx] && !sda_in) begin
                sda_low <= 1'b0;
                state   <= ARB_IDLE;
              end else if (bit_idx == 3'd0) begin
                won   <= 1'b1;
                state <= ARB_REL;
              end
            end else if (scl_fall) begin
              bit_idx <= nxt_idx;
              sda_low <= ~TX_BYTE[nxt_idx];
            end
          end
          ARB_REL: begin
            if (scl_fall) begin
              sda_low <= 1'b0;
              state   <= ARB_IDLE;
            end
          end
          default: state <= ARB_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_low = sda_low;
  assign ara_won      = won;

  assert_drop_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_TX && scl_rise && TX_BYTE[bit_idx] && !sda_in && !bus_start)
      |=> !sda_pull_low);
  assert_drive_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low |-> (state == ARB_ACK || state == ARB_TX || state == ARB_REL));
  assert_change_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_TX && !scl_rise && !scl_fall && !bus_start) |=> $stable(sda_pull_low));
endmodule

// File: rtl/alert_irq_ctrl.sv
module alert_irq_ctrl
  import alert_irq_pkg::*;
#(
  parameter int         EVT_W    = 8,
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_set,
  input  logic [EVT_W-1:0] evt_rdclr,
  input  logic [7:0]       reg_wdata,
  input  logic             mask_wr,
  input  logic             ctl_wr,
  input  logic             txn_active,
  input  logic             bus_start,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull_low,
  output logic             int_pull_low,
  output logic             int_pending,
  output logic [EVT_W-1:0] evt_flags
);
  logic [EVT_W-1:0] mask_q;
  logic             clr_all, rel_wr, cond, ara_won, int_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata[EVT_W-1:0];
  end

  assign clr_all = ctl_wr & reg_wdata[CTL_CLRA_BIT];
  assign rel_wr  = ctl_wr & reg_wdata[CTL_REL_BIT];
  assign cond    = |(evt_flags & mask_q);

  alert_evt_flags #(.EVT_W(EVT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_rdclr(evt_rdclr),
    .clr_all(clr_all), .flags(evt_flags)
  );

  alert_int_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cond(cond), .txn_active(txn_active),
    .release_in(rel_wr | ara_won), .int_pend(int_pend)
  );

  alert_ara_arb #(.DEV_ADDR(DEV_ADDR)) u_arb (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .scl_in(scl_in),
    .sda_in(sda_in), .int_pend(int_pend), .sda_pull_low(sda_pull_low),
    .ara_won(ara_won)
  );

  assign int_pull_low = int_pend;
  assign int_pending  = int_pend;

  assert_ack_needs_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> int_pend);
endmodule

// File: tb/alert_irq_ctrl_tb.sv
module alert_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_set = '0, evt_rdclr = '0, reg_wdata = '0;
  logic       mask_wr = 0, ctl_wr = 0, txn_active = 0, bus_start = 0;
  logic       scl = 1'b1, m_sda = 1'b1, other_low = 1'b0;
  logic       sda_pull_low, int_pull_low, int_pending;
  logic [7:0] evt_flags;
  logic       sda_line;
  int         n_vec = 0, n_err = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~other_low & ~sda_pull_low;

  alert_irq_ctrl #(.EVT_W(8), .DEV_ADDR(7'h2A)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_rdclr(evt_rdclr),
    .reg_wdata(reg_wdata), .mask_wr(mask_wr), .ctl_wr(ctl_wr),
    .txn_active(txn_active), .bus_start(bus_start), .scl_in(scl),
    .sda_in(sda_line), .sda_pull_low(sda_pull_low), .int_pull_low(int_pull_low),
    .int_pending(int_pending), .evt_flags(evt_flags)
  );

  // mask, set pulse, expected interrupt
  localparam logic [16:0] VECS [0:7] = '{
    {8'hF4, 8'h01, 1'b0}, {8'hF4, 8'h04, 1'b1}, {8'hF4, 8'h80, 1'b1},
    {8'h00, 8'hFF, 1'b0}, {8'hFF, 8'h02, 1'b1}, {8'h0F, 8'hF0, 1'b0},
    {8'hF4, 8'h08, 1'b0}, {8'h01, 8'h01, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [7:0] v);
    reg_wdata = v; mask_wr = 1; tick(1); mask_wr = 0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    reg_wdata = v; ctl_wr = 1; tick(1); ctl_wr = 0;
  endtask

  task automatic pulse_set(input logic [7:0] v);
    evt_set = v; tick(1); evt_set = '0;
  endtask

  task automatic pulse_clr(input logic [7:0] v);
    evt_rdclr = v; tick(1); evt_rdclr = '0;
  endtask

  task automatic clk_bit(input logic b);
    scl = 0; m_sda = b; tick(2); scl = 1; tick(2);
  endtask

  task automatic ara_txn(input logic [7:0] addr, input int lose_idx,
                         output logic acked, output logic [7:0] got,
                         output logic late_pull, output logic int_mid);
    logic lost;
    lost = 0; late_pull = 0;
    txn_active = 1; tick(1);
    bus_start = 1; tick(1); bus_start = 0;
    for (int i = 7; i >= 0; i--) clk_bit(addr[i]);
    scl = 0; m_sda = 1; tick(2); scl = 1; tick(2);
    acked = ~sda_line;
    for (int i = 7; i >= 0; i--) begin
      scl = 0; other_low = 0; tick(2);
      other_low = (i == lose_idx);
      scl = 1; tick(1);
      got[i] = sda_line;
      if (lost && sda_pull_low) late_pull = 1;
      tick(1);
      if (i == lose_idx) lost = 1;
    end
    scl = 0; other_low = 0; tick(2);
    int_mid = int_pull_low;
    clk_bit(1'b0);
    scl = 0; m_sda = 1; tick(2); scl = 1; tick(2);
    txn_active = 0;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic acked, late, mid;
    logic [7:0] got;
    tick(3); rst_n = 1; tick(1);
    chk("R3 reset int", int_pull_low, 0);
    chk("R7 reset sda", sda_pull_low, 0);
    chk("R1 reset flags", evt_flags, 0);

    // table walk: R1/R3
    for (int v = 0; v < 8; v++) begin
      wr_ctl(8'h80); tick(2);
      wr_mask(VECS[v][16:9]);
      pulse_set(VECS[v][8:1]);
      tick(3);
      chk("R3 table int", int_pull_low, VECS[v][0]);
      chk("R3 table status", int_pending, VECS[v][0]);
      chk("R1 table flags", evt_flags, VECS[v][8:1]);
    end
    wr_ctl(8'h80); tick(3);

    // R1 read-clear and set-wins
    wr_mask(8'h00);
    pulse_set(8'h03); pulse_clr(8'h01); tick(1);
    chk("R1 read-clear", evt_flags, 8'h02);
    evt_set = 8'h04; evt_rdclr = 8'h04; tick(1); evt_set = 0; evt_rdclr = 0; tick(1);
    chk("R1 set wins", evt_flags, 8'h06);
    wr_ctl(8'h80); tick(1);
    chk("R2 clear all", evt_flags, 8'h00);

    // R4 deferral
    wr_mask(8'hFF);
    txn_active = 1; pulse_set(8'h10); tick(4);
    chk("R4 no assert in txn", int_pull_low, 0);
    txn_active = 0; tick(3);
    chk("R4 assert after txn", int_pull_low, 1);
    txn_active = 1; wr_ctl(8'h80); tick(3);
    chk("R4 hold through clear", int_pull_low, 1);
    chk("R2 flags cleared in txn", evt_flags, 0);
    txn_active = 0; tick(3);
    chk("R3 drop after txn", int_pull_low, 0);

    // R5/R6 release and re-arm
    pulse_set(8'h01); tick(3);
    chk("R3 pending", int_pull_low, 1);
    wr_ctl(8'h40); tick(2);
    chk("R5 release", int_pull_low, 0);
    pulse_set(8'h02); tick(3);
    chk("R6 no reassert", int_pull_low, 0);
    pulse_clr(8'h03); tick(3);
    pulse_set(8'h04); tick(3);
    chk("R6 rearmed", int_pull_low, 1);
    txn_active = 1; wr_ctl(8'h40); tick(3);
    chk("R4 release deferred", int_pull_low, 1);
    txn_active = 0; tick(3);
    chk("R5 deferred release", int_pull_low, 0);
    wr_ctl(8'h80); tick(3);
    pulse_set(8'h01); tick(3);
    chk("R6 rearm after clear-all", int_pull_low, 1);

    // R7 wrong address
    ara_txn(8'h50, -1, acked, got, late, mid);
    chk("R7 no ack other addr", acked, 0);
    chk("R7 no drive other addr", got, 8'hFF);
    tick(3);
    chk("R7 int kept", int_pull_low, 1);

    // R9 lost arbitration on first 1 bit (index 6)
    ara_txn(8'h19, 6, acked, got, late, mid);
    chk("R7 ack", acked, 1);
    chk("R9 bits after loss", got, 8'h3F);
    chk("R9 released after loss", late, 0);
    tick(3);
    chk("R9 int kept", int_pull_low, 1);

    // R8/R10 won arbitration
    ara_txn(8'h19, -1, acked, got, late, mid);
    chk("R7 ack win", acked, 1);
    chk("R8 address sent", got, 8'h54);
    chk("R4 int held during read", mid, 1);
    tick(3);
    chk("R10 released after win", int_pull_low, 0);
    pulse_set(8'h20); tick(3);
    chk("R6 after win", int_pull_low, 0);

    // R7 no pending interrupt
    ara_txn(8'h19, -1, acked, got, late, mid);
    chk("R7 no ack without int", acked, 0);
    chk("R7 no drive without int", got, 8'hFF);

    done = 1;
    report();
  end
endmodule